// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a single-channel bus-master DMA controller. It follows a table of region descriptors held in memory and moves 32-bit words between a device-side data port and memory. Software provides a table pointer and a direction. A rising edge on the run bit starts the engine. The engine reads each 8-byte descriptor as two word reads, decodes the region's start address, its byte length and its final-entry flag, and transfers the region one word per beat. It then moves on to the next entry, which sits 8 bytes further along the table.

The length field is 16 bits wide and its lowest bit is ignored. A field of zero stands for a 65536-byte region. The walk has no fixed length and ends only when the region of an entry carrying the final flag has been transferred. A region start that is not word aligned is treated as an error, and so is a region that runs past a 64 KB boundary. A table pointer that is not 8-byte aligned is an error, as is a step to the next table entry that would leave the 64 KB segment of the current entry. Lowering the run bit stops the walk at the next safe point, even when entries remain.

Top module: `sg_dma_engine`

## Requirements
- R1: Out of reset, `sts_active`, `sts_done` and `sts_err` are low, and `mem_req`, `dev_tx_valid` and `dev_rx_ready` are low.
- R2: A rising edge of `cmd_start` while idle samples `tbl_base` and `cmd_dir`. Each descriptor is fetched as two word reads, at the entry pointer and at pointer+4. Successive entries are read at pointer+8.
- R3: The first descriptor word is the region byte address. In the second word, bits [15:1] give the length in bytes, bit 0 is ignored and bit 31 is the final-entry flag. A length of zero means 65536 bytes.
- R4: With `cmd_dir`=0 (memory to device), the engine reads the region's words in ascending address order. Each word read is presented unchanged on `dev_tx_data` and is held until `dev_tx_ready` is seen.
- R5: With `cmd_dir`=1 (device to memory), each word taken from the receive port is written at ascending addresses. Bit i of `mem_be` enables byte lane i. Writes use 4'b1111, except a final 2-byte beat, which uses 4'b0011. Every read uses 4'b1111.
- R6: Once the region of the final entry has been transferred, `sts_active` falls and `sts_done` rises in the same cycle, and no further memory request or device handshake is made.
- R7: A region whose address has bit 1 or bit 0 set, or whose address within its 64 KB segment plus its length exceeds 65536, sets `sts_err` and ends the walk without transferring any beat of that region.
- R8: A `tbl_base` with any of bits [2:0] set raises `sts_err` on the cycle after the start edge, without any memory request. A step from a non-final entry to a next entry in another 64 KB segment also sets `sts_err`.
- R9: Lowering `cmd_start` while active stops the walk at the next point where no read response is awaited. `sts_done` is set, and no further request or handshake follows.
- R10: `mem_req` and its address, write flag, enables and data hold until `mem_ack`, and `dev_tx_valid` with its data holds until `dev_tx_ready`. Either may drop only when `cmd_start` is low.
- R11: A new start clears `sts_done` and `sts_err`. `sts_done` and `sts_err` are never high together, and neither is high while `sts_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Run bit; rising edge starts, low stops |
| cmd_dir | input | 1 | 0: memory to device, 1: device to memory |
| tbl_base | input | 32 | Descriptor table byte address |
| sts_active | output | 1 | Walk in progress |
| sts_done | output | 1 | Walk finished or stopped |
| sts_err | output | 1 | Walk ended on an alignment or boundary fault |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address (word aligned) |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| dev_tx_valid | output | 1 | Word offered to the device |
| dev_tx_data | output | 32 | Word to the device |
| dev_tx_ready | input | 1 | Device takes the word |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_data | input | 32 | Word from the device |
| dev_rx_ready | output | 1 | Engine takes the offered word |

## Verification
The assertions assume a memory that acknowledges only a request that is raised and returns exactly one read response per acknowledged read, in a cycle after the acknowledge. They also assume that `cmd_start` changes only between clock edges. The bench's memory model holds to this: it decides an acknowledge only for a request that is visible at the falling edge, and it queues a single response behind it with its own random delay. All inputs change away from the rising edge, so the handshake rules on both ports see settled values. Random delays, random device readiness and randomly generated descriptor tables then vary the timing inside those limits.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_D0_REQ,
      S_D0_WAIT,
      S_D1_REQ,
      S_D1_WAIT,
      S_CHECK,
      S_RD_REQ,
      S_RD_WAIT,
      S_TX,
      S_RX,
      S_WR_REQ,
      S_STEP
   } walk_state_t;

endpackage

// File: rtl/sg_dma_desc_dec.sv
module sg_dma_desc_dec #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int SEG_W  = 16
) (
   input  logic [ADDR_W-1:0] addr_word,
   input  logic [LEN_W-1:1]  len_field,
   input  logic              eot_bit,
   output logic [ADDR_W-1:0] rgn_addr,
   output logic [LEN_W:0]    rgn_len,
   output logic              last_entry,
   output logic              mis_aligned,
   output logic              seg_cross
);

   localparam logic [LEN_W:0] FULL_LEN = (LEN_W+1)'(1) << LEN_W;

   logic [LEN_W-1:0] raw_len;

   assign raw_len     = {len_field, 1'b0};
   assign rgn_len     = (raw_len == '0) ? FULL_LEN : {1'b0, raw_len};
   assign rgn_addr    = addr_word;
   assign last_entry  = eot_bit;
   assign mis_aligned = |addr_word[1:0];

   generate
      if (SEG_W >= ADDR_W) begin : g_no_seg
         assign seg_cross = 1'b0;
      end else begin : g_seg
         localparam int SUM_W = SEG_W + 2;
         localparam logic [SUM_W-1:0] SEG_SIZE = SUM_W'(1) << SEG_W;
         logic [SUM_W-1:0] end_off;
         assign end_off   = SUM_W'(addr_word[SEG_W-1:0]) + SUM_W'(rgn_len);
         assign seg_cross = end_off > SEG_SIZE;
      end
   endgenerate

endmodule

// File: rtl/sg_dma_beat.sv
module sg_dma_beat #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 17
) (
   input  logic [CNT_W-1:0]    remain,
   input  logic                is_write,
   output logic [CNT_W-1:0]    beat_bytes,
   output logic [DATA_W/8-1:0] byte_en,
   output logic                final_beat
);

   localparam int BYTES = DATA_W / 8;
   localparam logic [CNT_W-1:0] BYTES_C = CNT_W'(BYTES);

   assign final_beat = remain <= BYTES_C;
   assign beat_bytes = final_beat ? remain : BYTES_C;

   generate
      for (genvar i = 0; i < BYTES; i++) begin : g_lane
         assign byte_en[i] = !is_write || (CNT_W'(i) < beat_bytes);
      end
   endgenerate

endmodule

// File: rtl/sg_dma_tblwalk.sv
module sg_dma_tblwalk #(
   parameter int ADDR_W  = 32,
   parameter int SEG_W   = 16,
   parameter int ENTRY_B = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base_in,
   output logic [ADDR_W-1:0] ptr,
   output logic              base_bad,
   output logic              next_cross
);

   localparam int AL_W = $clog2(ENTRY_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (load)    ptr <= base_in;
      else if (advance) ptr <= ptr + ADDR_W'(ENTRY_B);
   end

   assign base_bad = |base_in[AL_W-1:0];

   generate
      if (SEG_W >= ADDR_W) begin : g_flat
         assign next_cross = 1'b0;
      end else begin : g_seg
         logic [ADDR_W-1:0] nxt;
         assign nxt        = ptr + ADDR_W'(ENTRY_B);
         assign next_cross = nxt[ADDR_W-1:SEG_W] != ptr[ADDR_W-1:SEG_W];
      end
   endgenerate

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
   import sg_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   parameter int SEG_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_start,
   input  logic                cmd_dir,
   input  logic [ADDR_W-1:0]   tbl_base,
   output logic                sts_active,
   output logic                sts_done,
   output logic                sts_err,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic                mem_rvalid,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                dev_tx_valid,
   output logic [DATA_W-1:0]   dev_tx_data,
   input  logic                dev_tx_ready,
   input  logic                dev_rx_valid,
   input  logic [DATA_W-1:0]   dev_rx_data,
   output logic                dev_rx_ready
);

   localparam int BYTES   = DATA_W / 8;
   localparam int CNT_W   = LEN_W + 1;
   localparam int ENTRY_B = 8;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("sg_dma_engine: DATA_W must be 32");
      end
      if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
         $error("sg_dma_engine: ADDR_W must be 8..32");
      end
      if (LEN_W > 16 || LEN_W < 3) begin : g_bad_len
         $error("sg_dma_engine: LEN_W must be 3..16");
      end
      if (SEG_W < LEN_W) begin : g_bad_seg
         $error("sg_dma_engine: SEG_W must be at least LEN_W");
      end
   endgenerate

   walk_state_t st;
   logic              start_q;
   logic              dir_q;
   logic [ADDR_W-1:0] w0_q;
   logic [LEN_W-1:1]  len_fld_q;
   logic              eot_fld_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remain;
   logic [DATA_W-1:0] data_q;
   logic              act_q, done_q, err_q;

   logic [ADDR_W-1:0] ptr;
   logic              base_bad, next_cross, ptr_load, ptr_adv;
   logic [ADDR_W-1:0] dec_addr;
   logic [CNT_W-1:0]  dec_len;
   logic              dec_eot, dec_mis, dec_cross;
   logic [CNT_W-1:0]  beat_bytes;
   logic              final_beat;
   logic              start_rise, stoppable, stop_now;

   assign start_rise = cmd_start && !start_q;
   assign stoppable  = (st != S_IDLE) && (st != S_D0_WAIT) &&
                       (st != S_D1_WAIT) && (st != S_RD_WAIT);
   assign stop_now   = stoppable && !cmd_start;
   assign ptr_load   = (st == S_IDLE) && start_rise && !base_bad;
   assign ptr_adv    = (st == S_STEP) && cmd_start && final_beat &&
                       !dec_eot && !next_cross;

   sg_dma_tblwalk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .ENTRY_B(ENTRY_B)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ptr_load),
      .advance   (ptr_adv),
      .base_in   (tbl_base),
      .ptr       (ptr),
      .base_bad  (base_bad),
      .next_cross(next_cross)
   );

   sg_dma_desc_dec #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_W(SEG_W)) u_dec (
      .addr_word  (w0_q),
      .len_field  (len_fld_q),
      .eot_bit    (eot_fld_q),
      .rgn_addr   (dec_addr),
      .rgn_len    (dec_len),
      .last_entry (dec_eot),
      .mis_aligned(dec_mis),
      .seg_cross  (dec_cross)
   );

   sg_dma_beat #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_beat (
      .remain    (remain),
      .is_write  (st == S_WR_REQ),
      .beat_bytes(beat_bytes),
      .byte_en   (mem_be),
      .final_beat(final_beat)
   );

   // Port-side decode
   assign mem_req = cmd_start && ((st == S_D0_REQ) || (st == S_D1_REQ) ||
                                  (st == S_RD_REQ) || (st == S_WR_REQ));
   assign mem_we       = (st == S_WR_REQ);
   assign mem_wdata    = data_q;
   assign dev_tx_valid = cmd_start && (st == S_TX);
   assign dev_tx_data  = data_q;
   assign dev_rx_ready = cmd_start && (st == S_RX);
   assign sts_active   = act_q;
   assign sts_done     = done_q;
   assign sts_err      = err_q;

   always_comb begin
      case (st)
         S_D0_REQ: mem_addr = ptr;
         S_D1_REQ: mem_addr = ptr + ADDR_W'(4);
         default:  mem_addr = cur_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         start_q   <= 1'b0;
         dir_q     <= 1'b0;
         w0_q      <= '0;
         len_fld_q <= '0;
         eot_fld_q <= 1'b0;
         cur_addr  <= '0;
         remain    <= '0;
         data_q    <= '0;
         act_q     <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         start_q <= cmd_start;
         if (stop_now) begin
            st     <= S_IDLE;
            act_q  <= 1'b0;
            done_q <= 1'b1;
         end else begin
            case (st)
               S_IDLE: begin
                  if (start_rise) begin
                     done_q <= 1'b0;
                     dir_q  <= cmd_dir;
                     if (base_bad) begin
                        err_q <= 1'b1;
                     end else begin
                        err_q <= 1'b0;
                        act_q <= 1'b1;
                        st    <= S_D0_REQ;
                     end
                  end
               end
               S_D0_REQ:  if (mem_ack) st <= S_D0_WAIT;
               S_D0_WAIT: begin
                  if (mem_rvalid) begin
                     w0_q <= mem_rdata[ADDR_W-1:0];
                     st   <= S_D1_REQ;
                  end
               end
               S_D1_REQ:  if (mem_ack) st <= S_D1_WAIT;
               S_D1_WAIT: begin
                  if (mem_rvalid) begin
                     len_fld_q <= mem_rdata[LEN_W-1:1];
                     eot_fld_q <= mem_rdata[31];
                     st        <= S_CHECK;
                  end
               end
               S_CHECK: begin
                  if (dec_mis || dec_cross) begin
                     err_q <= 1'b1;
                     act_q <= 1'b0;
                     st    <= S_IDLE;
                  end else begin
                     cur_addr <= dec_addr;
                     remain   <= dec_len;
                     st       <= dir_q ? S_RX : S_RD_REQ;
                  end
               end
               S_RD_REQ:  if (mem_ack) st <= S_RD_WAIT;
               S_RD_WAIT: begin
                  if (mem_rvalid) begin
                     data_q <= mem_rdata;
                     st     <= S_TX;
                  end
               end
               S_TX: if (dev_tx_ready) st <= S_STEP;
               S_RX: begin
                  if (dev_rx_valid) begin
                     data_q <= dev_rx_data;
                     st     <= S_WR_REQ;
                  end
               end
               S_WR_REQ: if (mem_ack) st <= S_STEP;
               S_STEP: begin
                  if (final_beat) begin
                     act_q <= dec_eot ? 1'b0 : !next_cross;
                     if (dec_eot) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                     end else if (next_cross) begin
                        err_q <= 1'b1;
                        st    <= S_IDLE;
                     end else begin
                        st <= S_D0_REQ;
                     end
                  end else begin
                     cur_addr <= cur_addr + ADDR_W'(beat_bytes);
                     remain   <= remain - beat_bytes;
                     st       <= dir_q ? S_RX : S_RD_REQ;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req || !cmd_start);

   // R10
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> !mem_req ||
         ($stable(mem_addr) && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata)));

   // R10
   tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_tx_valid && !dev_tx_ready |=> !dev_tx_valid || $stable(dev_tx_data));

   // R5
   rd_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> (mem_be == '1));

   // R7
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_active |-> !mem_req && !dev_tx_valid && !dev_rx_ready);

   // R11
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sts_done && sts_err) && !(sts_active && (sts_done || sts_err)));

   // R9
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_active && !cmd_start && (st != S_D0_WAIT) && (st != S_D1_WAIT) &&
      (st != S_RD_WAIT) |=> !sts_active && sts_done);

   // R3
   rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RD_REQ || st == S_RX || st == S_TX || st == S_WR_REQ) |-> remain != '0);

endmodule

// File: tb/sg_dma_engine_test.sv
module sg_dma_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_dir = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        sts_active, sts_done, sts_err;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        dev_tx_valid, dev_rx_ready;
   logic [31:0] dev_tx_data;
   logic        dev_tx_ready = 1'b0;
   logic        dev_rx_valid = 1'b0;
   logic [31:0] dev_rx_data = '0;

   always #2.5 clk = ~clk;

   sg_dma_engine uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_dir(cmd_dir),
      .tbl_base(tbl_base), .sts_active(sts_active), .sts_done(sts_done),
      .sts_err(sts_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dev_tx_valid(dev_tx_valid),
      .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
      .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
      .dev_rx_ready(dev_rx_ready)
   );

   int checks = 0;
   int failures = 0;
   int cyc_all = 0;

   logic [31:0] d_w0 [0:15];
   logic [31:0] d_w1 [0:15];
   logic [31:0] tbl;
   bit          fast = 1'b0;
   int          n_ok, exp_fetch, exp_beats;
   bit          exp_err;
   int          sb_idx, sb_rem;
   logic [31:0] sb_addr;
   int          beats, acks, tbl_reads;
   logic [31:0] rx_word = 32'hC000_0000;
   logic [31:0] last_rx = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'h0000_9E37) ^ 32'h5A5A_1234;
   endfunction

   function automatic int dlen(input logic [15:0] f);
      return ((f & 16'hFFFE) == 16'h0) ? 65536 : int'(f & 16'hFFFE);
   endfunction

   task automatic set_desc(input int i, input logic [31:0] a,
                           input logic [15:0] lf, input bit eot);
      d_w0[i] = a;
      d_w1[i] = {eot, 15'h0, lf};
   endtask

   task automatic sb_load();
      if (sb_idx < n_ok) begin
         sb_addr = d_w0[sb_idx];
         sb_rem  = dlen(d_w1[sb_idx][15:0]);
      end
   endtask

   task automatic sb_step();
      sb_rem  = sb_rem - ((sb_rem >= 4) ? 4 : sb_rem);
      sb_addr = sb_addr + 4;
      beats++;
      if (sb_rem == 0) begin
         sb_idx++;
         sb_load();
      end
   endtask

   // expected outcome of a table walk
   task automatic plan();
      int l;
      logic [31:0] cur, nxt;
      n_ok = 0; exp_fetch = 0; exp_beats = 0; exp_err = 1'b0;
      if (tbl[2:0] != 3'b000) begin
         exp_err = 1'b1;
         return;
      end
      for (int i = 0; i < 16; i++) begin
         exp_fetch++;
         l = dlen(d_w1[i][15:0]);
         if (d_w0[i][1:0] != 2'b00 || (int'(d_w0[i][15:0]) + l) > 65536) begin
            exp_err = 1'b1;
            break;
         end
         n_ok++;
         exp_beats += (l + 3) / 4;
         if (d_w1[i][31]) break;
         cur = tbl + 32'(8 * i);
         nxt = cur + 32'd8;
         if (nxt[31:16] != cur[31:16]) begin
            exp_err = 1'b1;
            break;
         end
      end
   endtask

   // memory and device models, driven away from the active edge
   int          ack_wait = 0, rd_wait = 0;
   bit          rd_pend = 1'b0, hold_v = 1'b0;
   logic [31:0] rd_val, held_addr;

   function automatic logic [31:0] mem_read(input logic [31:0] a);
      logic [31:0] off;
      off = a - tbl;
      if (off < 32'd128) begin
         tbl_reads++;
         return off[2] ? d_w1[off[6:3]] : d_w0[off[6:3]];
      end
      return pat(a);
   endfunction

   always @(negedge clk) begin
      mem_ack    = 1'b0;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
         if (rd_wait == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd_val;
            rd_pend    = 1'b0;
         end else rd_wait--;
      end else if (mem_req) begin
         if (hold_v)
            chk(mem_addr == held_addr, "R10", "request address held", mem_addr, held_addr);
         if (ack_wait == 0) begin
            mem_ack  = 1'b1;
            hold_v   = 1'b0;
            ack_wait = fast ? 0 : int'($urandom % 4);
            acks++;
            if (mem_we) begin
               chk(mem_addr == sb_addr, "R5", "write address", mem_addr, sb_addr);
               chk(mem_be == ((sb_rem >= 4) ? 4'hF : 4'h3), "R5", "write enables",
                   mem_be, (sb_rem >= 4) ? 4'hF : 4'h3);
               chk(mem_wdata == last_rx, "R5", "write data", mem_wdata, last_rx);
               chk(sb_idx < n_ok, "R5", "write beyond table", sb_idx, n_ok);
               sb_step();
            end else begin
               if ((mem_addr - tbl) < 32'd128)
                  chk(mem_addr == tbl + 32'(4 * tbl_reads), "R2", "descriptor read address",
                      mem_addr, tbl + 32'(4 * tbl_reads));
               chk(mem_be == 4'hF, "R5", "read enables", mem_be, 4'hF);
               rd_val  = mem_read(mem_addr);
               rd_pend = 1'b1;
               rd_wait = fast ? 0 : int'($urandom % 3);
            end
         end else begin
            ack_wait--;
            hold_v    = 1'b1;
            held_addr = mem_addr;
         end
      end else hold_v = 1'b0;

      dev_tx_ready = fast ? 1'b1 : 1'($urandom % 2);
      if (dev_tx_valid && dev_tx_ready) begin
         chk(dev_tx_data == pat(sb_addr), "R4", "device word", dev_tx_data, pat(sb_addr));
         chk(sb_idx < n_ok, "R4", "beat beyond table", sb_idx, n_ok);
         sb_step();
      end

      dev_rx_valid = fast ? 1'b1 : 1'($urandom % 2);
      dev_rx_data  = rx_word;
      if (dev_rx_valid && dev_rx_ready) begin
         last_rx = rx_word;
         rx_word = rx_word + 32'd1;
      end
   end

   always @(posedge clk) begin
      cyc_all++;
      if (cyc_all > 190000) begin
         failures++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc_all, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run(input bit dir, input int stop_at, input string tag);
      int cyc, acks_end;
      plan();
      sb_idx = 0; beats = 0; acks = 0; tbl_reads = 0;
      sb_load();
      @(posedge clk); #1;
      cmd_dir = dir; tbl_base = tbl; cmd_start = 1'b1;
      @(posedge clk); #1;
      if (tbl[2:0] == 3'b000)
         chk(sts_active && !sts_done && !sts_err, "R11", "status after start",
             {sts_active, sts_done, sts_err}, 3'b100);
      cyc = 0;
      while (sts_active && cyc < 150000) begin
         if (stop_at > 0 && beats >= stop_at) cmd_start = 1'b0;
         @(posedge clk); #1;
         cyc++;
      end
      chk(cyc < 150000, tag, "walk finished", cyc, 150000);
      chk(!sts_active, tag, "inactive at end", sts_active, 0);
      if (stop_at > 0) begin
         chk(beats == stop_at, "R9", "beats before stop", beats, stop_at);
         chk(sts_done && !sts_err, "R9", "done after stop", {sts_done, sts_err}, 2'b10);
      end else begin
         chk(sts_err == exp_err, tag, "error flag", sts_err, exp_err);
         chk(sts_done == !exp_err, tag, "done flag", sts_done, !exp_err);
         chk(beats == exp_beats, tag, "beat count", beats, exp_beats);
         chk(tbl_reads == 2 * exp_fetch, "R2", "descriptor word reads", tbl_reads, 2 * exp_fetch);
      end
      acks_end = acks;
      repeat (8) @(posedge clk);
      #1;
      chk(acks == acks_end, (stop_at > 0) ? "R9" : "R6", "quiet after end", acks, acks_end);
      chk(!(sts_done && sts_err), "R11", "done and error exclusive", {sts_done, sts_err}, 0);
      cmd_start = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      void'($urandom(32'h0000_5EED));
      for (int i = 0; i < 16; i++) set_desc(i, 32'h0, 16'h4, 1'b1);
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(!sts_active && !sts_done && !sts_err, "R1", "status in reset",
          {sts_active, sts_done, sts_err}, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(!mem_req && !dev_tx_valid && !dev_rx_ready, "R1", "ports idle after reset",
          {mem_req, dev_tx_valid, dev_rx_ready}, 0);

      // R4 memory to device, two entries, short tail beat
      tbl = 32'h0000_8000;
      set_desc(0, 32'h0000_1000, 16'd16, 1'b0);
      set_desc(1, 32'h0000_2004, 16'd6, 1'b1);
      run(1'b0, 0, "R4");

      // R5 device to memory with a 2-byte final beat
      set_desc(0, 32'h0000_3000, 16'd10, 1'b1);
      run(1'b1, 0, "R5");

      // R3 bit 0 of the length field ignored (7 -> 6 bytes)
      set_desc(0, 32'h0000_3100, 16'd7, 1'b1);
      run(1'b1, 0, "R3");

      // R7 unaligned region
      set_desc(0, 32'h0000_1002, 16'd8, 1'b1);
      run(1'b0, 0, "R7");

      // R7 region overruns its segment; then exact fit at the boundary
      set_desc(0, 32'h0002_FFF0, 16'h20, 1'b1);
      run(1'b1, 0, "R7");
      set_desc(0, 32'h0002_FFF0, 16'h10, 1'b1);
      run(1'b1, 0, "R7");

      // R8 misaligned table pointer
      tbl = 32'h0000_8004;
      run(1'b0, 0, "R8");
      chk(acks == 0, "R8", "no request for bad table", acks, 0);

      // R8 next entry leaves the segment
      tbl = 32'h0003_FFF8;
      set_desc(0, 32'h0000_1000, 16'd8, 1'b0);
      set_desc(1, 32'h0000_2000, 16'd8, 1'b1);
      run(1'b0, 0, "R8");

      // R9 stop in the middle of a long region
      tbl = 32'h0000_8000;
      set_desc(0, 32'h0000_4000, 16'd256, 1'b1);
      run(1'b0, 10, "R9");

      // R6 random tables in both directions
      for (int r = 0; r < 10; r++) begin
         int n;
         n   = 1 + int'($urandom % 4);
         tbl = 32'h0000_8000 + 32'(8 * ($urandom % 64));
         for (int i = 0; i < n; i++)
            set_desc(i, {16'h0010 + 16'($urandom % 16), 16'(($urandom % 32'h3F00) & 32'hFFFC)},
                     16'(2 * (1 + $urandom % 32)), i == n - 1);
         run(1'($urandom % 2), 0, "R6");
      end

      // R3 zero length means 65536 bytes
      fast = 1'b1;
      tbl  = 32'h0000_8000;
      set_desc(0, 32'h0005_0000, 16'h0000, 1'b1);
      run(1'b1, 0, "R3");
      fast = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule